// File: doc/BRIEF.md
# UART FIFO Control with Receive Trigger

This block holds the FIFO configuration byte of a UART and the two byte queues that sit between the serial shifters and the rest of the chip. It has one 16-entry queue per direction. The receiver core pushes received bytes into the receive queue, and the host side drains it. The host side fills the transmit queue, and the transmitter core drains it. The block reports how full each queue is. It also raises a data-available condition once the receive queue holds at least a chosen number of bytes.

Configuration is a single byte written through `cfg_wr`/`cfg_wdata`. The byte carries:
- an enable bit;
- two one-shot clear commands, one per queue;
- a two-bit receive threshold selector.

Changing the enable bit in either direction flushes both queues. The clear commands are never stored.

Every data path is a valid/ready stream. A consumer may pop only when `*_out_valid` is high; a pop with `*_out_valid` low changes nothing. A producer should hold off while `*_in_ready` is low. The shifters cannot stall, though, so the block accepts a valid byte when `*_in_ready` is low but discards it and reports the loss. Configuration and status pins are plain signals.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset, the enable bit and the threshold selector are 0, both queues are empty, both `*_in_ready` are high, and `rx_avail` and both overrun flags are low.
- R2: A configuration write whose bit 0 differs from the current enable flushes both queues in the same clock edge. This holds for 0-to-1 and for 1-to-0. The new enable value appears on `fifo_en` after that edge.
- R3: A write with bit 0 = 1 and bit 1 = 1 empties only the receive queue. The command is not stored: a later write without bit 1 does not clear again.
- R4: A write with bit 0 = 1 and bit 2 = 1 empties only the transmit queue. This command is not stored either.
- R5: A write with bit 0 = 1 and bits 1 and 2 at 0 leaves the contents of both queues unchanged.
- R6: Bits 7:6 select the receive threshold, visible on `rx_trig_sel`: 00 selects 1, 01 selects 4, 10 selects 8, 11 selects 14. `rx_avail` is high exactly while `rx_count` is at or above the selected threshold.
- R7: When bit 0 of a write is 0, bits 7:1 are ignored. The threshold selector keeps its value, and no clear happens beyond the one R2 may cause.
- R8: Each queue returns bytes in arrival order and holds up to 16. `*_in_ready` is high while the count is below 16. `*_out_valid` is high while the count is above 0. `*_out_data` shows the oldest byte.
- R9: A valid input while the queue is full is dropped. The count does not rise, and the matching overrun flag is high for exactly the next cycle.
- R10: A pop from an empty queue leaves the count at 0. While a queue is empty, `*_out_data` shows the last byte popped from it, or 0 if none has been popped since reset.
- R11: A clear and a push to the same queue in the same cycle leave that queue empty, and no overrun is reported.
- R12: A push and a pop in the same cycle on a queue that is neither empty nor full leave its count unchanged and move the data in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte |
| fifo_en | output | 1 | Stored enable bit |
| rx_trig_sel | output | 2 | Stored receive threshold selector |
| rx_in_valid | input | 1 | Receiver core offers a byte |
| rx_in_ready | output | 1 | Receive queue has room |
| rx_in_data | input | 8 | Received byte |
| rx_out_valid | output | 1 | Receive queue not empty |
| rx_out_ready | input | 1 | Host pops a byte |
| rx_out_data | output | 8 | Oldest received byte, or last popped byte when empty |
| rx_count | output | 5 | Receive queue occupancy |
| rx_overrun | output | 1 | One-cycle pulse after a dropped receive byte |
| rx_avail | output | 1 | Receive count at or above threshold |
| tx_in_valid | input | 1 | Host offers a byte to send |
| tx_in_ready | output | 1 | Transmit queue has room |
| tx_in_data | input | 8 | Byte to send |
| tx_out_valid | output | 1 | Transmit queue not empty |
| tx_out_ready | input | 1 | Transmitter core pops a byte |
| tx_out_data | output | 8 | Oldest byte to send, or last popped byte when empty |
| tx_count | output | 5 | Transmit queue occupancy |
| tx_overrun | output | 1 | One-cycle pulse after a dropped transmit byte |

## Verification
- **Data ordering:** bursts of distinct bytes fill the queues partially and then completely, and are drained interleaved with new pushes. This shows whether ordering, the full boundary and the overrun pulse are correct, and separates a dropped byte from an overwritten one.
- **Thresholds:** the receive count is walked up and down across each of the four thresholds. This separates an off-by-one comparison from a wrong level decode.
- **Configuration bytes:**
  - A byte that sets both clear bits is compared with bytes that set only one. This tells the receive clear apart from the transmit clear.
  - The enable bit is toggled in both directions and also rewritten with its current value. This separates the flush caused by a change from one caused by any write.
  - Writes with bit 0 low but other bits set show whether the gating works.
- **Same-cycle collisions:** clears arrive together with pushes, and pops together with pushes. These expose a wrong priority.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  localparam int CFG_EN_BIT    = 0;
  localparam int CFG_RXCLR_BIT = 1;
  localparam int CFG_TXCLR_BIT = 2;
  localparam int CFG_TRIG_LSB  = 6;

  typedef enum logic [1:0] {
    TRIG_ONE      = 2'b00,
    TRIG_FOUR     = 2'b01,
    TRIG_EIGHT    = 2'b10,
    TRIG_FOURTEEN = 2'b11
  } rx_trig_e;

  function automatic int unsigned trig_depth(rx_trig_e sel);
    case (sel)
      TRIG_ONE:   return 1;
      TRIG_FOUR:  return 4;
      TRIG_EIGHT: return 8;
      default:    return 14;
    endcase
  endfunction

endpackage

// File: rtl/uart_fifo_cfg.sv
module uart_fifo_cfg
  import uart_fifo_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  logic [7:0] wdata,
  output logic     en,
  output rx_trig_e trig,
  output logic     clr_rx,
  output logic     clr_tx
);

  logic     en_q;
  rx_trig_e trig_q;
  logic     flip;
  logic     armed;
  logic     unused_bits;

  assign unused_bits = ^wdata[5:3];

  // A change of the enable bit flushes both queues; the other fields count
  // only when the same write keeps the enable bit set.
  assign flip   = wr && (wdata[CFG_EN_BIT] != en_q);
  assign armed  = wr && wdata[CFG_EN_BIT];
  assign clr_rx = flip || (armed && wdata[CFG_RXCLR_BIT]);
  assign clr_tx = flip || (armed && wdata[CFG_TXCLR_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      trig_q <= TRIG_ONE;
    end else if (wr) begin
      en_q <= wdata[CFG_EN_BIT];
      if (wdata[CFG_EN_BIT]) begin
        trig_q <= rx_trig_e'(wdata[CFG_TRIG_LSB +: 2]);
      end
    end
  end

  assign en   = en_q;
  assign trig = trig_q;

  // R7: a write with the enable bit low leaves the threshold selector alone
  assert_gated_trig_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wdata[CFG_EN_BIT]) |=> (trig == $past(trig)));

  // R2: the enable output follows bit 0 of every write
  assert_en_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (en == $past(wdata[CFG_EN_BIT])));

endmodule

// File: rtl/uart_fifo_buf.sv
module uart_fifo_buf #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] count,
  output logic          overrun
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  last_q;
  logic          ovr_q;
  logic          full, empty, push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = in_valid && !full;
  assign pop_ok  = out_ready && !empty;

  generate
    if ((1 << PW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_mod
      assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
      last_q <= '0;
      ovr_q  <= 1'b0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      ovr_q <= in_valid && full;
      if (push_ok) wr_ptr <= wr_nxt;
      if (pop_ok) begin
        rd_ptr <= rd_nxt;
        last_q <= mem[rd_ptr];
      end
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!clr && push_ok) mem[wr_ptr] <= in_data;
  end

  assign in_ready  = !full;
  assign out_valid = !empty;
  assign out_data  = empty ? last_q : mem[rd_ptr];
  assign count     = cnt_q;
  assign overrun   = ovr_q;

  // R8: occupancy never exceeds the depth
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R9: a byte offered to a full queue is reported one cycle later
  assert_drop_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !clr) |=> overrun);

  // R11: a clear wins over anything else in the same cycle
  assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0) && !overrun);

  // R10: popping an empty queue with no push keeps the shown byte
  assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && out_ready && !in_valid && !clr) |=> ($stable(out_data) && count == '0));

  // R12: push and pop together in the middle keep occupancy
  assert_balanced_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_valid && out_ready && !clr) |=> $stable(count));

endmodule

// File: rtl/uart_rx_trigger.sv
module uart_rx_trigger
  import uart_fifo_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic [CW-1:0] count,
  input  rx_trig_e      sel,
  output logic          avail
);

  logic [CW-1:0] thr;

  always_comb begin
    thr   = CW'(trig_depth(sel));
    avail = (count >= thr);
  end

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  output logic              fifo_en,
  output logic [1:0]        rx_trig_sel,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  input  logic [DATA_W-1:0] rx_in_data,
  output logic              rx_out_valid,
  input  logic              rx_out_ready,
  output logic [DATA_W-1:0] rx_out_data,
  output logic [CW-1:0]     rx_count,
  output logic              rx_overrun,
  output logic              rx_avail,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [DATA_W-1:0] tx_in_data,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [DATA_W-1:0] tx_out_data,
  output logic [CW-1:0]     tx_count,
  output logic              tx_overrun
);

  rx_trig_e trig;
  logic     clr_rx, clr_tx;

  uart_fifo_cfg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_wr),
    .wdata  (cfg_wdata),
    .en     (fifo_en),
    .trig   (trig),
    .clr_rx (clr_rx),
    .clr_tx (clr_tx)
  );

  assign rx_trig_sel = trig;

  uart_fifo_buf #(.W(DATA_W), .DEPTH(DEPTH)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr_rx),
    .in_valid  (rx_in_valid),
    .in_ready  (rx_in_ready),
    .in_data   (rx_in_data),
    .out_valid (rx_out_valid),
    .out_ready (rx_out_ready),
    .out_data  (rx_out_data),
    .count     (rx_count),
    .overrun   (rx_overrun)
  );

  uart_fifo_buf #(.W(DATA_W), .DEPTH(DEPTH)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr_tx),
    .in_valid  (tx_in_valid),
    .in_ready  (tx_in_ready),
    .in_data   (tx_in_data),
    .out_valid (tx_out_valid),
    .out_ready (tx_out_ready),
    .out_data  (tx_out_data),
    .count     (tx_count),
    .overrun   (tx_overrun)
  );

  uart_rx_trigger #(.CW(CW)) u_trig (
    .count (rx_count),
    .sel   (trig),
    .avail (rx_avail)
  );

  // R2: changing the enable bit empties both queues at that edge
  assert_en_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (cfg_wdata[CFG_EN_BIT] != fifo_en)) |=> (rx_count == '0 && tx_count == '0));

  // R3: a receive clear leaves the transmit count to its own traffic
  assert_rx_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_wdata[CFG_EN_BIT] && fifo_en && cfg_wdata[CFG_RXCLR_BIT]
     && !cfg_wdata[CFG_TXCLR_BIT] && !tx_in_valid && !tx_out_ready)
    |=> (rx_count == '0 && $stable(tx_count)));

  // R6: the available flag rises only on a larger count or a new level
  assert_avail_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_avail) |-> ((rx_count > $past(rx_count)) || (rx_trig_sel != $past(rx_trig_sel))));

endmodule

// File: tb/test_uart_fifo_ctrl.sv
module test_uart_fifo_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       fifo_en;
  logic [1:0] rx_trig_sel;
  logic       rx_in_valid = 1'b0, rx_out_ready = 1'b0;
  logic [7:0] rx_in_data = '0;
  logic       rx_in_ready, rx_out_valid, rx_overrun, rx_avail;
  logic [7:0] rx_out_data;
  logic [4:0] rx_count;
  logic       tx_in_valid = 1'b0, tx_out_ready = 1'b0;
  logic [7:0] tx_in_data = '0;
  logic       tx_in_ready, tx_out_valid, tx_overrun;
  logic [7:0] tx_out_data;
  logic [4:0] tx_count;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_fifo_ctrl i_uart_fifo_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .fifo_en(fifo_en), .rx_trig_sel(rx_trig_sel),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data),
    .rx_count(rx_count), .rx_overrun(rx_overrun), .rx_avail(rx_avail),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .tx_count(tx_count), .tx_overrun(tx_overrun)
  );

  // reference model state
  logic [7:0] rxq[$];
  logic [7:0] txq[$];
  logic [7:0] m_rx_last = '0, m_tx_last = '0;
  bit         m_en = 0;
  bit [1:0]   m_trig = 0;
  bit         m_rx_ovr = 0, m_tx_ovr = 0;

  function automatic int thr_of(bit [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R8 rx_count", int'(rx_count), rxq.size());
    chk("R8 tx_count", int'(tx_count), txq.size());
    chk("R8 rx_in_ready", int'(rx_in_ready), int'(rxq.size() < DEPTH));
    chk("R8 tx_in_ready", int'(tx_in_ready), int'(txq.size() < DEPTH));
    chk("R8 rx_out_valid", int'(rx_out_valid), int'(rxq.size() > 0));
    chk("R8 tx_out_valid", int'(tx_out_valid), int'(txq.size() > 0));
    chk("R10 rx_out_data", int'(rx_out_data), int'(rxq.size() > 0 ? rxq[0] : m_rx_last));
    chk("R10 tx_out_data", int'(tx_out_data), int'(txq.size() > 0 ? txq[0] : m_tx_last));
    chk("R6 rx_avail", int'(rx_avail), int'(rxq.size() >= thr_of(m_trig)));
    chk("R9 rx_overrun", int'(rx_overrun), int'(m_rx_ovr));
    chk("R9 tx_overrun", int'(tx_overrun), int'(m_tx_ovr));
    chk("R2 fifo_en", int'(fifo_en), int'(m_en));
    chk("R7 rx_trig_sel", int'(rx_trig_sel), int'(m_trig));
  endtask

  // one clock: model update at the edge, comparison at the falling edge
  task automatic cyc();
    bit c_rx, c_tx, rx_pop, tx_pop, rx_push, tx_push;
    @(posedge clk);
    c_rx = 0;
    c_tx = 0;
    if (cfg_wr) begin
      if (cfg_wdata[0] != m_en) begin c_rx = 1; c_tx = 1; end
      if (cfg_wdata[0]) begin
        if (cfg_wdata[1]) c_rx = 1;
        if (cfg_wdata[2]) c_tx = 1;
        m_trig = cfg_wdata[7:6];
      end
      m_en = cfg_wdata[0];
    end
    m_rx_ovr = rx_in_valid && (rxq.size() == DEPTH) && !c_rx;
    m_tx_ovr = tx_in_valid && (txq.size() == DEPTH) && !c_tx;
    if (c_rx) rxq.delete();
    else begin
      rx_pop  = rx_out_ready && rxq.size() > 0;
      rx_push = rx_in_valid && rxq.size() < DEPTH;
      if (rx_pop) m_rx_last = rxq.pop_front();
      if (rx_push) rxq.push_back(rx_in_data);
    end
    if (c_tx) txq.delete();
    else begin
      tx_pop  = tx_out_ready && txq.size() > 0;
      tx_push = tx_in_valid && txq.size() < DEPTH;
      if (tx_pop) m_tx_last = txq.pop_front();
      if (tx_push) txq.push_back(tx_in_data);
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic cfg(logic [7:0] v);
    cfg_wr = 1; cfg_wdata = v; cyc(); cfg_wr = 0; cfg_wdata = '0;
  endtask

  task automatic rx_push1(logic [7:0] d);
    rx_in_valid = 1; rx_in_data = d; cyc(); rx_in_valid = 0;
  endtask

  task automatic tx_push1(logic [7:0] d);
    tx_in_valid = 1; tx_in_data = d; cyc(); tx_in_valid = 0;
  endtask

  task automatic rx_pop1();
    rx_out_ready = 1; cyc(); rx_out_ready = 0;
  endtask

  task automatic tx_pop1();
    tx_out_ready = 1; cyc(); tx_out_ready = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1 fifo_en", int'(fifo_en), 0);
    chk("R1 rx_trig_sel", int'(rx_trig_sel), 0);
    chk("R1 rx_count", int'(rx_count), 0);
    chk("R1 tx_in_ready", int'(tx_in_ready), 1);
    chk("R1 rx_avail", int'(rx_avail), 0);
    compare_all();

    // R2: enable 0->1
    cfg(8'h01);
    chk("R2 enabled", int'(fifo_en), 1);

    // R8: ordering with distinct patterns
    for (int i = 0; i < 5; i++) rx_push1(8'hA0 + 8'(i));
    for (int i = 0; i < 3; i++) tx_push1(8'h5A ^ 8'(i * 17));
    rx_pop1();
    chk("R8 head after pop", int'(rx_out_data), 8'hA1);
    tx_pop1();

    // R6: threshold levels
    cfg(8'h41);
    chk("R6 four reached", int'(rx_avail), 1);
    rx_pop1();
    chk("R6 below four", int'(rx_avail), 0);
    cfg(8'h81);
    for (int i = 0; i < 5; i++) rx_push1(8'h10 + 8'(i));
    chk("R6 eight reached", int'(rx_avail), 1);
    cfg(8'hC1);
    chk("R6 fourteen not yet", int'(rx_avail), 0);
    for (int i = 0; i < 5; i++) rx_push1(8'h20 + 8'(i));
    chk("R6 fourteen", int'(rx_avail), int'(rx_count >= 14));

    // R9: fill and overrun
    while (rx_count < 16) rx_push1(8'h77);
    rx_push1(8'hEE);
    chk("R9 count held", int'(rx_count), 16);
    chk("R9 pulse", int'(rx_overrun), 1);
    cyc();
    chk("R9 pulse ends", int'(rx_overrun), 0);

    // R12: push and pop together
    rx_pop1();
    rx_in_valid = 1; rx_in_data = 8'h3C; rx_out_ready = 1; cyc();
    rx_in_valid = 0; rx_out_ready = 0;
    chk("R12 count kept", int'(rx_count), 15);

    // R5: write without clear bits
    cfg(8'h01);
    chk("R5 rx kept", int'(rx_count), 15);
    chk("R5 tx kept", int'(tx_count), 2);

    // R3: receive clear only, then not repeated
    cfg(8'h03);
    chk("R3 rx empty", int'(rx_count), 0);
    chk("R3 tx kept", int'(tx_count), 2);
    rx_push1(8'h91);
    cfg(8'h01);
    chk("R3 not stored", int'(rx_count), 1);

    // R4: transmit clear only
    cfg(8'h05);
    chk("R4 tx empty", int'(tx_count), 0);
    chk("R4 rx kept", int'(rx_count), 1);

    // R10: pop empty
    tx_pop1();
    chk("R10 tx count", int'(tx_count), 0);
    rx_pop1();
    rx_pop1();
    chk("R10 rx last", int'(rx_out_data), 8'h91);

    // R11: clear together with push
    rx_push1(8'h42);
    while (rx_count < 16) rx_push1(8'h43);
    rx_in_valid = 1; rx_in_data = 8'h44; cfg(8'h03); rx_in_valid = 0;
    chk("R11 empty", int'(rx_count), 0);
    chk("R11 no overrun", int'(rx_overrun), 0);

    // R7 / R2: disable with junk bits
    cfg(8'h81);
    rx_push1(8'h55);
    tx_push1(8'h66);
    cfg(8'hC6);
    chk("R7 trig kept", int'(rx_trig_sel), 2);
    chk("R2 flush on disable", int'(rx_count + tx_count), 0);
    rx_push1(8'h12);
    tx_push1(8'h34);
    cfg(8'h46);
    chk("R7 no clear when off", int'(rx_count), 1);
    chk("R7 trig still kept", int'(rx_trig_sel), 2);
    cfg(8'h01);
    chk("R2 flush on enable", int'(rx_count + tx_count), 0);

    repeat (2) cyc();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule